// File: doc/BRIEF.md
# Descriptor Staging and Commit Port

This block is the write-side front end of a scatter-gather transfer engine. Software writes a 32-byte transfer descriptor as eight 32-bit words through a simple word-addressed write port. The first seven words are held in a staging register. The descriptor enters the descriptor queue as a whole, and only when the control word (word index 7) is written with its commit bit (bit 31) set. A write of any other word never enqueues anything. Staged words survive a commit, so a stream of similar descriptors only needs the changed words rewritten before each commit.

The queue keeps every descriptor at its full 256 bits. It presents it as two views. The read-side view carries the source address, the read burst and the read stride. The write-side view carries the destination address, the write burst and the write stride. Both views carry the length, the sequence number and the control fields. Each view is consumed by its own mover through an independent pop, and has its own fill level. Empty, full and a sticky overflow flag report the queue state.

Top module: `desc_commit_port`

## Requirements
- R1: After reset both fill levels are 0, `empty_o` is 1, `full_o`, `overflow_o`, `rd_valid_o` and `wr_valid_o` are 0.
- R2: Word index 0 is the read address low, 1 the write address low, 2 the length, 5 the read address high and 6 the write address high. A committed descriptor shows `rd_addr_o` = {word5, word0}, `wr_addr_o` = {word6, word1} and `rd_len_o` = `wr_len_o` = word2.
- R3: Word 3 splits as follows: bits 31:24 appear on `wr_burst_o`, bits 23:16 on `rd_burst_o`, and bits 15:0 on both `rd_seq_o` and `wr_seq_o`.
- R4: Word 4 splits as follows: bits 31:16 appear on `wr_stride_o` and bits 15:0 on `rd_stride_o`.
- R5: A write to word 7 with bit 31 set, while `full_o` is 0, pushes the staged words 0..6 together with the written control word. Both fill levels then rise by one at the next clock edge, unless that side is popped in the same cycle.
- R6: A write to word 7 with bit 31 clear, or a write to any of words 0..6, leaves both fill levels unchanged.
- R7: Staged words keep their values after a commit. A descriptor committed after rewriting only some words carries the earlier values in all the other words.
- R8: `rd_ctrl_o` and `wr_ctrl_o` carry bits 24:0 of the committed control word: bits 7:0 channel, bit 8 start-of-packet, bit 9 end-of-packet, bit 10 park reads, bit 11 park writes, bit 12 end on end-of-packet, bit 13 end on length, bit 14 completion interrupt, bit 15 early-termination interrupt, bits 23:16 error interrupt mask, bit 24 early done.
- R9: A commit while `full_o` is 1 is dropped, leaving both fill levels unchanged, and sets `overflow_o`. `overflow_o` then stays 1 until reset.
- R10: The two sides are popped independently and each returns descriptors in commit order. A pop lowers only its own side's fill level, and a pop while that side's fill level is 0 has no effect.
- R11: `full_o` is 1 exactly when either fill level equals DEPTH (default 8). `empty_o` is 1 exactly when both fill levels are 0.
- R12: `rd_fill_o` and `wr_fill_o` report the number of descriptors committed and not yet popped on that side. `rd_valid_o`/`wr_valid_o` are 1 when that side's fill level is nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Descriptor word write strobe |
| wr_idx_i | input | 3 | Word index (7 = control word) |
| wr_data_i | input | 32 | Write data |
| rd_pop_i | input | 1 | Read-side mover consumes head descriptor |
| wr_pop_i | input | 1 | Write-side mover consumes head descriptor |
| rd_valid_o | output | 1 | Read-side head valid |
| rd_addr_o | output | 64 | Read-side source address |
| rd_len_o | output | 32 | Length in bytes |
| rd_burst_o | output | 8 | Read burst (0 = maximum) |
| rd_stride_o | output | 16 | Read stride |
| rd_seq_o | output | 16 | Sequence number |
| rd_ctrl_o | output | 25 | Control fields |
| wr_valid_o | output | 1 | Write-side head valid |
| wr_addr_o | output | 64 | Write-side destination address |
| wr_len_o | output | 32 | Length in bytes |
| wr_burst_o | output | 8 | Write burst (0 = maximum) |
| wr_stride_o | output | 16 | Write stride |
| wr_seq_o | output | 16 | Sequence number |
| wr_ctrl_o | output | 25 | Control fields |
| rd_fill_o | output | 16 | Read-side fill level |
| wr_fill_o | output | 16 | Write-side fill level |
| empty_o | output | 1 | Both sides empty |
| full_o | output | 1 | No room for another commit |
| overflow_o | output | 1 | Sticky: a commit was dropped while full |

## Verification
Directed sequences come first. One stages words and writes the control word without the commit bit, which tells a commit-on-any-write design apart from one that commits on bit 31. Another rewrites a single word between two commits, which exposes staging that clears on commit. A third fills the queue past DEPTH and drains each side separately, which separates the per-side counters from a shared one and shows the drop on full. Random traffic with all-ones, all-zeros and random word data then mixes commits, non-committing writes and skewed pops. Every view field is compared against a bench model, which catches swapped halves of the burst and stride words.

// File: rtl/desc_pkg.sv
package desc_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned N_WORDS = 8;
  localparam int unsigned CTRL_W  = 25;
  localparam int unsigned CTRL_IDX = 7;

  // member order puts word 0 at the LSB
  typedef struct packed {
    logic [31:0] ctrl;
    logic [31:0] dst_hi;
    logic [31:0] src_hi;
    logic [31:0] stride;
    logic [31:0] burst_seq;
    logic [31:0] len;
    logic [31:0] dst_lo;
    logic [31:0] src_lo;
  } desc_t;

  typedef enum logic {SIDE_RD = 1'b0, SIDE_WR = 1'b1} side_e;
endpackage

// File: rtl/desc_stage.sv
module desc_stage
  import desc_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [2:0]  wr_idx_i,
  input  logic [31:0] wr_data_i,
  output logic        commit_o,
  output desc_t       desc_o
);
  localparam int unsigned N_STAGED = N_WORDS - 1;

  logic [N_STAGED-1:0][WORD_W-1:0] stage_q;

  for (genvar g = 0; g < N_STAGED; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[g] <= '0;
      else if (wr_en_i && wr_idx_i == 3'(g)) stage_q[g] <= wr_data_i;
    end
  end

  assign commit_o = wr_en_i && (wr_idx_i == 3'(CTRL_IDX)) && wr_data_i[31];

  // control word goes straight from the bus into the pushed entry
  assign desc_o = desc_t'({wr_data_i, stage_q});
endmodule

// File: rtl/desc_store.sv
module desc_store
  import desc_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  desc_t            desc_i,
  input  logic             rd_pop_i,
  input  logic             wr_pop_i,
  output desc_t            rd_head_o,
  output desc_t            wr_head_o,
  output logic [CNT_W-1:0] rd_cnt_o,
  output logic [CNT_W-1:0] wr_cnt_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             overflow_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  desc_t            mem_q [DEPTH];
  logic [PTR_W-1:0] wptr_q, rptr_rd_q, rptr_wr_q;
  logic [CNT_W-1:0] cnt_rd_q, cnt_wr_q;
  logic             ovf_q;
  logic             push_ok, pop_rd, pop_wr;

  function automatic logic [PTR_W-1:0] ptr_next(logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (cnt_rd_q == CNT_MAX) || (cnt_wr_q == CNT_MAX);
  assign empty_o = (cnt_rd_q == '0) && (cnt_wr_q == '0);
  assign push_ok = push_i && !full_o;
  assign pop_rd  = rd_pop_i && (cnt_rd_q != '0);
  assign pop_wr  = wr_pop_i && (cnt_wr_q != '0);

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wptr_q] <= desc_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q    <= '0;
      rptr_rd_q <= '0;
      rptr_wr_q <= '0;
      cnt_rd_q  <= '0;
      cnt_wr_q  <= '0;
      ovf_q     <= 1'b0;
    end else begin
      if (push_ok) wptr_q <= ptr_next(wptr_q);
      if (pop_rd)  rptr_rd_q <= ptr_next(rptr_rd_q);
      if (pop_wr)  rptr_wr_q <= ptr_next(rptr_wr_q);
      cnt_rd_q <= cnt_rd_q + CNT_W'(push_ok) - CNT_W'(pop_rd);
      cnt_wr_q <= cnt_wr_q + CNT_W'(push_ok) - CNT_W'(pop_wr);
      if (push_i && full_o) ovf_q <= 1'b1;
    end
  end

  assign rd_head_o  = mem_q[rptr_rd_q];
  assign wr_head_o  = mem_q[rptr_wr_q];
  assign rd_cnt_o   = cnt_rd_q;
  assign wr_cnt_o   = cnt_wr_q;
  assign overflow_o = ovf_q;

  p_cnt_bound_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_rd_q <= CNT_MAX) && (cnt_wr_q <= CNT_MAX));
  p_ovf_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |=> ovf_q);
  p_ptr_sync_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_rd_q == cnt_wr_q) |-> (rptr_rd_q == rptr_wr_q));
endmodule

// File: rtl/desc_view.sv
module desc_view
  import desc_pkg::*;
#(
  parameter side_e SIDE = SIDE_RD
) (
  input  desc_t              desc_i,
  output logic [63:0]        addr_o,
  output logic [31:0]        len_o,
  output logic [7:0]         burst_o,
  output logic [15:0]        stride_o,
  output logic [15:0]        seq_o,
  output logic [CTRL_W-1:0]  ctrl_o
);
  if (SIDE == SIDE_RD) begin : g_rd
    assign addr_o   = {desc_i.src_hi, desc_i.src_lo};
    assign burst_o  = desc_i.burst_seq[23:16];
    assign stride_o = desc_i.stride[15:0];
  end else begin : g_wr
    assign addr_o   = {desc_i.dst_hi, desc_i.dst_lo};
    assign burst_o  = desc_i.burst_seq[31:24];
    assign stride_o = desc_i.stride[31:16];
  end
  assign len_o  = desc_i.len;
  assign seq_o  = desc_i.burst_seq[15:0];
  assign ctrl_o = desc_i.ctrl[CTRL_W-1:0];
endmodule

// File: rtl/desc_commit_port.sv
module desc_commit_port
  import desc_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned FILL_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_idx_i,
  input  logic [31:0]       wr_data_i,
  input  logic              rd_pop_i,
  input  logic              wr_pop_i,
  output logic              rd_valid_o,
  output logic [63:0]       rd_addr_o,
  output logic [31:0]       rd_len_o,
  output logic [7:0]        rd_burst_o,
  output logic [15:0]       rd_stride_o,
  output logic [15:0]       rd_seq_o,
  output logic [24:0]       rd_ctrl_o,
  output logic              wr_valid_o,
  output logic [63:0]       wr_addr_o,
  output logic [31:0]       wr_len_o,
  output logic [7:0]        wr_burst_o,
  output logic [15:0]       wr_stride_o,
  output logic [15:0]       wr_seq_o,
  output logic [24:0]       wr_ctrl_o,
  output logic [FILL_W-1:0] rd_fill_o,
  output logic [FILL_W-1:0] wr_fill_o,
  output logic              empty_o,
  output logic              full_o,
  output logic              overflow_o
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic             commit;
  desc_t            staged, rd_head, wr_head;
  logic [CNT_W-1:0] rd_cnt, wr_cnt;

  desc_stage i_stage (
    .clk_i, .rst_ni, .wr_en_i, .wr_idx_i, .wr_data_i,
    .commit_o (commit),
    .desc_o   (staged)
  );

  desc_store #(.DEPTH(DEPTH)) i_store (
    .clk_i, .rst_ni,
    .push_i     (commit),
    .desc_i     (staged),
    .rd_pop_i,
    .wr_pop_i,
    .rd_head_o  (rd_head),
    .wr_head_o  (wr_head),
    .rd_cnt_o   (rd_cnt),
    .wr_cnt_o   (wr_cnt),
    .full_o,
    .empty_o,
    .overflow_o
  );

  desc_view #(.SIDE(SIDE_RD)) i_view_rd (
    .desc_i (rd_head), .addr_o (rd_addr_o), .len_o (rd_len_o),
    .burst_o (rd_burst_o), .stride_o (rd_stride_o), .seq_o (rd_seq_o),
    .ctrl_o (rd_ctrl_o)
  );

  desc_view #(.SIDE(SIDE_WR)) i_view_wr (
    .desc_i (wr_head), .addr_o (wr_addr_o), .len_o (wr_len_o),
    .burst_o (wr_burst_o), .stride_o (wr_stride_o), .seq_o (wr_seq_o),
    .ctrl_o (wr_ctrl_o)
  );

  assign rd_fill_o  = FILL_W'(rd_cnt);
  assign wr_fill_o  = FILL_W'(wr_cnt);
  assign rd_valid_o = (rd_cnt != '0);
  assign wr_valid_o = (wr_cnt != '0);

  logic commit_req, no_pop;
  assign commit_req = wr_en_i && (wr_idx_i == 3'd7) && wr_data_i[31];
  assign no_pop     = !rd_pop_i && !wr_pop_i;

  p_commit_fill_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_req && !full_o && no_pop) |=>
      (rd_fill_o == $past(rd_fill_o) + 1'b1) && (wr_fill_o == $past(wr_fill_o) + 1'b1));
  p_no_commit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!commit_req && no_pop) |=> $stable(rd_fill_o) && $stable(wr_fill_o));
  p_drop_full_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_req && full_o && no_pop) |=> $stable(rd_fill_o) && overflow_o);
  p_pop_empty_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_pop_i && !rd_valid_o && !commit_req) |=> (rd_fill_o == '0));
  p_empty_flag_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> (!rd_valid_o && !wr_valid_o));
endmodule

// File: tb/test_desc_commit_port.sv
module test_desc_commit_port;
  localparam int DEPTH = 8;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, rd_pop = 0, wr_pop = 0;
  logic [2:0] wr_idx = 0;
  logic [31:0] wr_data = 0;
  logic rd_valid, wr_valid, empty, full, overflow;
  logic [63:0] rd_addr, wr_addr;
  logic [31:0] rd_len, wr_len;
  logic [7:0] rd_burst, wr_burst;
  logic [15:0] rd_stride, wr_stride, rd_seq, wr_seq, rd_fill, wr_fill;
  logic [24:0] rd_ctrl, wr_ctrl;

  always #10 clk = ~clk;

  desc_commit_port i_desc_commit_port (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .rd_pop_i(rd_pop), .wr_pop_i(wr_pop),
    .rd_valid_o(rd_valid), .rd_addr_o(rd_addr), .rd_len_o(rd_len), .rd_burst_o(rd_burst),
    .rd_stride_o(rd_stride), .rd_seq_o(rd_seq), .rd_ctrl_o(rd_ctrl),
    .wr_valid_o(wr_valid), .wr_addr_o(wr_addr), .wr_len_o(wr_len), .wr_burst_o(wr_burst),
    .wr_stride_o(wr_stride), .wr_seq_o(wr_seq), .wr_ctrl_o(wr_ctrl),
    .rd_fill_o(rd_fill), .wr_fill_o(wr_fill), .empty_o(empty), .full_o(full),
    .overflow_o(overflow)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] stg [7];
  logic [255:0] q_rd[$], q_wr[$];
  bit m_ovf = 0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] w(logic [255:0] e, int i);
    return e[32*i +: 32];
  endfunction

  task automatic check_all();
    logic [255:0] h;
    chk("R12 rd fill", rd_fill, q_rd.size());
    chk("R12 wr fill", wr_fill, q_wr.size());
    chk("R12 rd valid", rd_valid, q_rd.size() != 0);
    chk("R12 wr valid", wr_valid, q_wr.size() != 0);
    chk("R11 empty", empty, q_rd.size() == 0 && q_wr.size() == 0);
    chk("R11 full", full, q_rd.size() == DEPTH || q_wr.size() == DEPTH);
    chk("R9 overflow", overflow, m_ovf);
    if (q_rd.size() != 0) begin
      h = q_rd[0];
      chk("R2 rd addr", rd_addr, {w(h,5), w(h,0)});
      chk("R2 rd len", rd_len, w(h,2));
      chk("R3 rd burst", rd_burst, w(h,3)[23:16]);
      chk("R3 rd seq", rd_seq, w(h,3)[15:0]);
      chk("R4 rd stride", rd_stride, w(h,4)[15:0]);
      chk("R8 rd ctrl", rd_ctrl, w(h,7)[24:0]);
    end
    if (q_wr.size() != 0) begin
      h = q_wr[0];
      chk("R2 wr addr", wr_addr, {w(h,6), w(h,1)});
      chk("R2 wr len", wr_len, w(h,2));
      chk("R3 wr burst", wr_burst, w(h,3)[31:24]);
      chk("R3 wr seq", wr_seq, w(h,3)[15:0]);
      chk("R4 wr stride", wr_stride, w(h,4)[31:16]);
      chk("R8 wr ctrl", wr_ctrl, w(h,7)[24:0]);
    end
  endtask

  // drive one cycle, update model for the coming edge, check at next negedge
  task automatic step(bit we, logic [2:0] idx, logic [31:0] d, bit rp, bit wp);
    bit is_full, cmt;
    logic [255:0] e;
    wr_en = we; wr_idx = idx; wr_data = d; rd_pop = rp; wr_pop = wp;
    is_full = (q_rd.size() == DEPTH) || (q_wr.size() == DEPTH);
    cmt = we && idx == 3'd7 && d[31];
    if (cmt) e = {d, stg[6], stg[5], stg[4], stg[3], stg[2], stg[1], stg[0]};
    if (rp && q_rd.size() != 0) void'(q_rd.pop_front());
    if (wp && q_wr.size() != 0) void'(q_wr.pop_front());
    if (cmt && !is_full) begin q_rd.push_back(e); q_wr.push_back(e); end
    if (cmt && is_full) m_ovf = 1;
    if (we && idx < 3'd7) stg[idx] = d;
    @(negedge clk);
    check_all();
  endtask

  initial begin
    logic [63:0] keep_addr;
    logic [15:0] pf;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 7; i++) stg[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 empty", empty, 1); chk("R1 full", full, 0); chk("R1 ovf", overflow, 0);
    chk("R1 rd fill", rd_fill, 0); chk("R1 wr fill", wr_fill, 0);
    chk("R1 valid", {rd_valid, wr_valid}, 0);
    // stage a descriptor
    step(1, 0, 32'h1000_0040, 0, 0); step(1, 1, 32'h2000_0080, 0, 0);
    step(1, 2, 32'h0000_0200, 0, 0); step(1, 3, 32'hA5C3_0011, 0, 0);
    step(1, 4, 32'h0004_0008, 0, 0); step(1, 5, 32'h0000_0001, 0, 0);
    step(1, 6, 32'h0000_0002, 0, 0);
    // R6 control write without commit bit
    step(1, 7, 32'h0100_FFFF, 0, 0);
    chk("R6 no push on bit31 clear", rd_fill, 0);
    // R5 commit
    step(1, 7, 32'h8100_710A, 0, 0);
    chk("R5 fill after commit", {rd_fill, wr_fill}, {16'd1, 16'd1});
    keep_addr = rd_addr;
    // R7 rewrite only length, commit again
    step(1, 2, 32'h0000_0333, 0, 0);
    step(1, 7, 32'h8000_2000, 0, 0);
    step(0, 0, 0, 1, 0);
    chk("R7 retained rd addr", rd_addr, keep_addr);
    chk("R7 new len", rd_len, 32'h333);
    // R10 sides independent
    chk("R10 wr side untouched", wr_fill, 2);
    chk("R10 rd side popped", rd_fill, 1);
    // R9 fill to full and overflow
    for (int i = 0; i < DEPTH; i++) step(1, 7, 32'h8000_0000 | i, 0, 0);
    chk("R11 full at DEPTH", full, 1);
    pf = wr_fill;
    step(1, 7, 32'h80FF_FFFF, 0, 0);
    chk("R9 dropped", wr_fill, pf);
    chk("R9 overflow set", overflow, 1);
    // R10 drain with extra pops at empty
    for (int i = 0; i < DEPTH + 3; i++) step(0, 0, 0, 1, 1);
    chk("R10 drained", {rd_fill, wr_fill}, 0);
    chk("R9 overflow sticky", overflow, 1);
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      int unsigned r = $urandom_range(0, 9);
      logic [31:0] d;
      case ($urandom_range(0, 3))
        0: d = '1; 1: d = '0; default: d = $urandom();
      endcase
      if (r < 3) d[31] = 1'b1;
      step(r < 7, (r < 3) ? 3'd7 : 3'($urandom_range(0, 7)), d,
           $urandom_range(0, 2) == 0, $urandom_range(0, 3) == 0);
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule